// File: doc/BRIEF.md
# Sensor Readout Sync Generator

This block produces the line and frame timing for a progressive-scan image sensor readout. It runs on the master clock. It generates a data clock at half that rate, a pixel counter and a line counter, and two region codes that tell downstream shutter and clamp logic what the current position is. The pixel code marks a position as dummy, effective, optical-black or invalid. The line code marks a line as dummy, effective or invalid.

Each line has four parts: a short light-shielded dummy lead-in, the effective pixels, an optical-black strip and an invalid tail. A frame has dummy lines, effective lines and invalid lines. A mode input switches between the full 525-line frame and a 263-line monitoring frame that runs at twice the frame rate.

With internal sync selected, the block runs from its own counters and drives active-low line and frame pulses. With external sync selected, those outputs stay idle and the counters lock to line-start and frame-start pulses, which are sampled on the master clock. A read-enable input halts everything while it is low.

Top module: `sensor_sync_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the pixel counter, the line counter and the data clock are all 0.
- R2: While read_en is high and no external restart occurs, dclk toggles on every master clock. The pixel counter advances by one on the edge where dclk goes from 1 to 0.
- R3: A line holds PIX_DUMMY+PIX_ACTIVE+PIX_BLACK+PIX_BLANK pixels (780 by default). In internal sync the pixel counter wraps from the last pixel to 0, and the line counter advances on that same edge.
- R4: pix_region is 0 for the dummy pixels, 1 for the effective pixels, 2 for the optical-black pixels and 3 for the invalid tail. The regions come in that order, starting at pixel 0.
- R5: With mon_mode low, a frame has LN_DUMMY+LN_ACTIVE_NRM+LN_BLANK_NRM lines (2+492+31 by default). line_region is 0 for the dummy lines, 1 for the effective lines and 3 for the invalid lines. In internal sync the line counter wraps to 0 after the last line.
- R6: With mon_mode high, a frame has LN_DUMMY+LN_ACTIVE_MON+LN_BLANK_MON lines (2+244+17 by default), with the same line_region coding as R5. A line counter at or beyond the last line wraps to 0 at the end of the line.
- R7: In internal sync, hd_n is low for the first HD_CLKS master clocks of every line (line position = 2*pix_cnt+dclk < HD_CLKS). vd_n is low for the whole of line 0.
- R8: In external sync, hd_n and vd_n are held high.
- R9: In external sync with read_en high, a rising edge on line_start_in has the following effect one clock later: pix_cnt is 0, dclk is 0 and the line counter has advanced by one. The line counter does not advance past the last line of the frame.
- R10: In external sync with read_en high, a rising edge on frame_start_in has the following effect one clock later: the line counter, pix_cnt and dclk are all 0. If it coincides with a line-start edge, the frame-start edge wins.
- R11: In external sync, when no line-start edge arrives, the pixel counter stops at the last pixel and the line counter does not change. dclk keeps toggling.
- R12: While read_en is low, pix_cnt, line_cnt, dclk, hd_n and vd_n hold their values. Sync edges that arrive during the halt are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | 1 = external sync, 0 = internal sync |
| mon_mode | input | 1 | 1 = 263-line monitoring frame, 0 = 525-line frame |
| read_en | input | 1 | 1 = readout runs, 0 = readout halted |
| line_start_in | input | 1 | External line-start pulse, rising edge used |
| frame_start_in | input | 1 | External frame-start pulse, rising edge used |
| dclk | output | 1 | Data clock at half the master clock |
| hd_n | output | 1 | Active-low line sync (internal sync only) |
| vd_n | output | 1 | Active-low frame sync (internal sync only) |
| pix_cnt | output | PIX_W | Pixel position within the line |
| line_cnt | output | LINE_W | Line position within the frame |
| pix_region | output | 2 | Pixel region code (R4) |
| line_region | output | 2 | Line region code (R5, R6) |

## Verification
A wrong phase or pixel count shows up on dclk and pix_cnt at the next master clock. It also shows on hd_n and pix_region within one data clock, because both are decoded from that state. A line counter error, such as a wrap at the wrong boundary or a mode that is picked up late, appears on line_cnt and vd_n at the first line end after it occurs. That is at most one line of master clocks away. The bench compares every output on every cycle against a reference model, and it applies random external pulses, random halts and mode switches. Errors in sync-edge handling therefore appear one clock after the pulse that triggers them.

// File: rtl/ss_pkg.sv
package ss_pkg;
    typedef enum logic [1:0] {
        RGN_DUMMY  = 2'd0,
        RGN_ACTIVE = 2'd1,
        RGN_BLACK  = 2'd2,
        RGN_BLANK  = 2'd3
    } region_e;
endpackage

// File: rtl/ss_region_dec.sv
// Maps a position to a region code using three ascending boundaries.
module ss_region_dec #(
    parameter int W = 10
) (
    input  logic [W-1:0]    pos,
    input  logic [W-1:0]    b_dummy_end,
    input  logic [W-1:0]    b_active_end,
    input  logic [W-1:0]    b_black_end,
    output ss_pkg::region_e code
);
    always_comb begin
        if (pos < b_dummy_end)       code = ss_pkg::RGN_DUMMY;
        else if (pos < b_active_end) code = ss_pkg::RGN_ACTIVE;
        else if (pos < b_black_end)  code = ss_pkg::RGN_BLACK;
        else                         code = ss_pkg::RGN_BLANK;
    end
endmodule

// File: rtl/ss_pix_counter.sv
// Data clock phase and pixel position within a line.
module ss_pix_counter #(
    parameter  int LINE_PIX = 780,
    localparam int PIX_W    = $clog2(LINE_PIX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             restart,
    input  logic             hold_end,
    output logic             phase,
    output logic [PIX_W-1:0] pix,
    output logic             line_end
);
    localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(LINE_PIX - 1);

    typedef struct packed {
        logic             phase;
        logic [PIX_W-1:0] pix;
    } pc_st_t;

    pc_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        line_end = 1'b0;
        if (restart) begin
            st_d.phase = 1'b0;
            st_d.pix   = '0;
        end else if (adv) begin
            if (!st_q.phase) begin
                st_d.phase = 1'b1;
            end else begin
                st_d.phase = 1'b0;
                if (st_q.pix == PIX_LAST) begin
                    if (!hold_end) begin
                        st_d.pix = '0;
                        line_end = 1'b1;
                    end
                end else begin
                    st_d.pix = st_q.pix + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase = st_q.phase;
    assign pix   = st_q.pix;

    // R2: running data clock flips every master clock
    a_r2_dclk_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !restart |=> phase != $past(phase));

    // R12: halted readout keeps position and phase
    a_r12_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !adv && !restart |=> $stable(pix) && $stable(phase));

    // R3: line end returns the pixel counter to the first pixel
    a_r3_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> pix == '0 && !phase);
endmodule

// File: rtl/ss_line_counter.sv
// Line position within the frame; wraps in internal sync, saturates in external.
module ss_line_counter #(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              clear,
    input  logic              sat,
    input  logic [LINE_W-1:0] last,
    output logic [LINE_W-1:0] line
);
    typedef struct packed {
        logic [LINE_W-1:0] line;
    } lc_st_t;

    lc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.line = '0;
        end else if (inc) begin
            if (st_q.line >= last) begin
                if (!sat) st_d.line = '0;
            end else begin
                st_d.line = st_q.line + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line = st_q.line;

    // R10: a clear always lands on line 0
    a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> line == '0);

    // R9: saturating mode never leaves the last line by incrementing
    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        sat && inc && !clear && line == last |=> line == $past(last));
endmodule

// File: rtl/sensor_sync_gen.sv
module sensor_sync_gen #(
    parameter  int PIX_DUMMY     = 2,
    parameter  int PIX_ACTIVE    = 660,
    parameter  int PIX_BLACK     = 30,
    parameter  int PIX_BLANK     = 88,
    parameter  int LN_DUMMY      = 2,
    parameter  int LN_ACTIVE_NRM = 492,
    parameter  int LN_BLANK_NRM  = 31,
    parameter  int LN_ACTIVE_MON = 244,
    parameter  int LN_BLANK_MON  = 17,
    parameter  int HD_CLKS       = 40,
    localparam int LINE_PIX      = PIX_DUMMY + PIX_ACTIVE + PIX_BLACK + PIX_BLANK,
    localparam int NRM_LINES     = LN_DUMMY + LN_ACTIVE_NRM + LN_BLANK_NRM,
    localparam int MON_LINES     = LN_DUMMY + LN_ACTIVE_MON + LN_BLANK_MON,
    localparam int MAX_LINES     = (NRM_LINES > MON_LINES) ? NRM_LINES : MON_LINES,
    localparam int PIX_W         = $clog2(LINE_PIX),
    localparam int LINE_W        = $clog2(MAX_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_mode,
    input  logic              mon_mode,
    input  logic              read_en,
    input  logic              line_start_in,
    input  logic              frame_start_in,
    output logic              dclk,
    output logic              hd_n,
    output logic              vd_n,
    output logic [PIX_W-1:0]  pix_cnt,
    output logic [LINE_W-1:0] line_cnt,
    output logic [1:0]        pix_region,
    output logic [1:0]        line_region
);
    localparam logic [LINE_W-1:0] NRM_LAST    = LINE_W'(NRM_LINES - 1);
    localparam logic [LINE_W-1:0] MON_LAST    = LINE_W'(MON_LINES - 1);
    localparam logic [LINE_W-1:0] LN_DUM_END  = LINE_W'(LN_DUMMY);
    localparam logic [LINE_W-1:0] NRM_EFF_END = LINE_W'(LN_DUMMY + LN_ACTIVE_NRM);
    localparam logic [LINE_W-1:0] MON_EFF_END = LINE_W'(LN_DUMMY + LN_ACTIVE_MON);
    localparam logic [PIX_W-1:0]  PX_DUM_END  = PIX_W'(PIX_DUMMY);
    localparam logic [PIX_W-1:0]  PX_EFF_END  = PIX_W'(PIX_DUMMY + PIX_ACTIVE);
    localparam logic [PIX_W-1:0]  PX_BLK_END  = PIX_W'(PIX_DUMMY + PIX_ACTIVE + PIX_BLACK);
    localparam logic [PIX_W:0]    HD_POS_END  = (PIX_W+1)'(HD_CLKS);

    // Previous samples of the external sync inputs, for edge detection
    typedef struct packed {
        logic ls;
        logic fs;
    } sync_st_t;

    sync_st_t sy_d, sy_q;

    logic              ls_edge, fs_edge, go_ext;
    logic              pc_restart, pc_line_end, pc_phase;
    logic [PIX_W-1:0]  pc_pix;
    logic              lc_inc, lc_clear;
    logic [LINE_W-1:0] lc_line, frame_last, eff_end;
    logic [PIX_W:0]    line_pos;
    ss_pkg::region_e   px_code, ln_code;

    always_comb begin
        sy_d.ls    = line_start_in;
        sy_d.fs    = frame_start_in;
        ls_edge    = line_start_in & ~sy_q.ls;
        fs_edge    = frame_start_in & ~sy_q.fs;
        go_ext     = ext_mode & read_en;
        pc_restart = go_ext & (ls_edge | fs_edge);
        lc_clear   = go_ext & fs_edge;
        lc_inc     = ext_mode ? (go_ext & ls_edge & ~fs_edge) : pc_line_end;
        frame_last = mon_mode ? MON_LAST : NRM_LAST;
        eff_end    = mon_mode ? MON_EFF_END : NRM_EFF_END;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    ss_pix_counter #(
        .LINE_PIX (LINE_PIX)
    ) u_pix (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (read_en),
        .restart  (pc_restart),
        .hold_end (ext_mode),
        .phase    (pc_phase),
        .pix      (pc_pix),
        .line_end (pc_line_end)
    );

    ss_line_counter #(
        .LINE_W (LINE_W)
    ) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (lc_inc),
        .clear (lc_clear),
        .sat   (ext_mode),
        .last  (frame_last),
        .line  (lc_line)
    );

    ss_region_dec #(
        .W (PIX_W)
    ) u_px_dec (
        .pos          (pc_pix),
        .b_dummy_end  (PX_DUM_END),
        .b_active_end (PX_EFF_END),
        .b_black_end  (PX_BLK_END),
        .code         (px_code)
    );

    // Frame has no black band: black boundary equals active boundary
    ss_region_dec #(
        .W (LINE_W)
    ) u_ln_dec (
        .pos          (lc_line),
        .b_dummy_end  (LN_DUM_END),
        .b_active_end (eff_end),
        .b_black_end  (eff_end),
        .code         (ln_code)
    );

    assign line_pos    = {pc_pix, pc_phase};
    assign dclk        = pc_phase;
    assign pix_cnt     = pc_pix;
    assign line_cnt    = lc_line;
    assign pix_region  = px_code;
    assign line_region = ln_code;
    assign hd_n        = ext_mode | (line_pos >= HD_POS_END);
    assign vd_n        = ext_mode | (lc_line != '0);

    // R7: frame pulse starts only at the top of a frame
    a_r7_vd_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode && $past(!ext_mode) && $fell(vd_n) |-> line_cnt == '0 && pix_cnt == '0);

    // R7: line pulse starts only at the first master clock of a line
    a_r7_hd_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode && $past(!ext_mode) && $fell(hd_n) |-> pix_cnt == '0 && !dclk);

    // R9: external line-start edge realigns the line
    a_r9_line_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode && read_en && line_start_in && !sy_q.ls |=> pix_cnt == '0 && !dclk);

    // R10: external frame-start edge returns to the first line
    a_r10_frame_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode && read_en && frame_start_in && !sy_q.fs |=> line_cnt == '0 && pix_cnt == '0);
endmodule

// File: tb/tb_sensor_sync_gen.sv
module tb_sensor_sync_gen;
    localparam int PD = 2, PA = 8, PB = 3, PX = 4;
    localparam int LD = 2, LAN = 6, LBN = 3, LAM = 3, LBM = 2;
    localparam int HDC = 6;
    localparam int LP = PD + PA + PB + PX;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ext_mode = 1'b0, mon_mode = 1'b0, read_en = 1'b1;
    logic line_start_in = 1'b0, frame_start_in = 1'b0;
    logic dclk, hd_n, vd_n;
    logic [4:0] pix_cnt;
    logic [3:0] line_cnt;
    logic [1:0] pix_region, line_region;

    int checks = 0, errors = 0;
    int m_ph, m_pix, m_line, m_ls, m_fs;

    always #5 clk = ~clk;

    sensor_sync_gen #(
        .PIX_DUMMY(PD), .PIX_ACTIVE(PA), .PIX_BLACK(PB), .PIX_BLANK(PX),
        .LN_DUMMY(LD), .LN_ACTIVE_NRM(LAN), .LN_BLANK_NRM(LBN),
        .LN_ACTIVE_MON(LAM), .LN_BLANK_MON(LBM), .HD_CLKS(HDC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .mon_mode(mon_mode),
        .read_en(read_en), .line_start_in(line_start_in), .frame_start_in(frame_start_in),
        .dclk(dclk), .hd_n(hd_n), .vd_n(vd_n), .pix_cnt(pix_cnt), .line_cnt(line_cnt),
        .pix_region(pix_region), .line_region(line_region)
    );

    function automatic int f_last();
        return mon_mode ? (LD + LAM + LBM - 1) : (LD + LAN + LBN - 1);
    endfunction

    function automatic int f_pix_rgn(int p);
        if (p < PD) return 0;
        if (p < PD + PA) return 1;
        if (p < PD + PA + PB) return 2;
        return 3;
    endfunction

    function automatic int f_line_rgn(int l);
        if (l < LD) return 0;
        if (l < LD + (mon_mode ? LAM : LAN)) return 1;
        return 3;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference step for the coming clock edge, using the inputs now applied
    task automatic model_step();
        int ls_e, fs_e;
        ls_e = (line_start_in && !m_ls) ? 1 : 0;
        fs_e = (frame_start_in && !m_fs) ? 1 : 0;
        m_ls = line_start_in;
        m_fs = frame_start_in;
        if (read_en) begin
            if (ext_mode && (ls_e != 0 || fs_e != 0)) begin
                m_ph = 0; m_pix = 0;
                if (fs_e != 0) m_line = 0;
                else if (m_line < f_last()) m_line++;
            end else if (m_ph == 0) begin
                m_ph = 1;
            end else begin
                m_ph = 0;
                if (m_pix == LP - 1) begin
                    if (!ext_mode) begin
                        m_pix = 0;
                        m_line = (m_line >= f_last()) ? 0 : m_line + 1;
                    end
                end else begin
                    m_pix++;
                end
            end
        end
    endtask

    task automatic compare();
        int exp_hd, exp_vd;
        string ltag;
        exp_hd = ext_mode ? 1 : (((m_pix * 2 + m_ph) < HDC) ? 0 : 1);
        exp_vd = ext_mode ? 1 : ((m_line == 0) ? 0 : 1);
        ltag = ext_mode ? "R9 line_cnt" : (mon_mode ? "R6 line_cnt" : "R5 line_cnt");
        chk(dclk == m_ph[0], "R2 dclk", dclk, m_ph);
        chk(pix_cnt == m_pix, "R3 pix_cnt", pix_cnt, m_pix);
        chk(line_cnt == m_line, ltag, line_cnt, m_line);
        chk(pix_region == f_pix_rgn(m_pix), "R4 pix_region", pix_region, f_pix_rgn(m_pix));
        chk(line_region == f_line_rgn(m_line), mon_mode ? "R6 line_region" : "R5 line_region",
            line_region, f_line_rgn(m_line));
        chk(hd_n == exp_hd[0], ext_mode ? "R8 hd_n" : "R7 hd_n", hd_n, exp_hd);
        chk(vd_n == exp_vd[0], ext_mode ? "R8 vd_n" : "R7 vd_n", vd_n, exp_vd);
    endtask

    task automatic cyc();
        model_step();
        @(negedge clk);
        compare();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int hold_pix, hold_line;
        void'($urandom(32'h1357_2468));
        m_ph = 0; m_pix = 0; m_line = 0; m_ls = 0; m_fs = 0;
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        chk(pix_cnt == 0 && line_cnt == 0 && dclk == 0, "R1 reset state", {pix_cnt, line_cnt}, 0);
        rst_n = 1'b1;
        compare();
        chk(pix_cnt == 0 && line_cnt == 0 && dclk == 0, "R1 after release", {pix_cnt, line_cnt}, 0);

        // R5: three full normal frames, internal sync
        repeat (3 * LP * 2 * 11) cyc();

        // R12: halt in internal sync
        hold_pix = pix_cnt; hold_line = line_cnt;
        read_en = 1'b0;
        repeat (20) cyc();
        chk(pix_cnt == hold_pix, "R12 pix held", pix_cnt, hold_pix);
        chk(line_cnt == hold_line, "R12 line held", line_cnt, hold_line);
        read_en = 1'b1;

        // R6: monitoring frames
        mon_mode = 1'b1;
        repeat (2 * LP * 2 * 7 + 9) cyc();

        // R10: coinciding frame and line edges in external sync
        ext_mode = 1'b1; mon_mode = 1'b0;
        repeat (7) cyc();
        line_start_in = 1'b1; frame_start_in = 1'b1;
        cyc();
        chk(line_cnt == 0 && pix_cnt == 0 && dclk == 0, "R10 frame wins", line_cnt, 0);
        line_start_in = 1'b0; frame_start_in = 1'b0;
        repeat (5) cyc();

        // R9: a line edge advances the line and realigns
        line_start_in = 1'b1;
        cyc();
        chk(line_cnt == 1 && pix_cnt == 0 && dclk == 0, "R9 line edge", line_cnt, 1);
        line_start_in = 1'b0;

        // R11: no further edge, pixel counter parks at the last pixel
        repeat (60) cyc();
        chk(pix_cnt == LP - 1, "R11 pix parked", pix_cnt, LP - 1);
        chk(line_cnt == 1, "R11 line unchanged", line_cnt, 1);

        // R12: edges during a halt are ignored
        read_en = 1'b0;
        line_start_in = 1'b1; frame_start_in = 1'b1;
        cyc();
        line_start_in = 1'b0; frame_start_in = 1'b0;
        repeat (4) cyc();
        chk(line_cnt == 1 && pix_cnt == LP - 1, "R12 edges ignored", line_cnt, 1);
        read_en = 1'b1;

        // Random segments: modes, halts and external pulses
        for (int seg = 0; seg < 40; seg++) begin
            ext_mode = ($urandom % 3 == 0);
            mon_mode = ($urandom % 2 == 0);
            for (int i = 0; i < 600; i++) begin
                read_en = ($urandom % 16 != 0);
                line_start_in = ext_mode && ($urandom % 30 == 0);
                frame_start_in = ext_mode && ($urandom % 400 == 0);
                cyc();
            end
        end
        line_start_in = 1'b0; frame_start_in = 1'b0;

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule